// File: doc/BRIEF.md
# Asynchronous Processor Bus Port with TDM Memory Arbitration

This block is the host-side access port of a time-division switch. A processor on an 8-bit, non-multiplexed, asynchronous bus reaches a control register and 32 channel locations through chip-select, data-strobe and read/write inputs. The block answers each access with an active-low acknowledge. The control register decides which internal store the channel locations address: connection memory high, connection memory low, or the data memory.

The connection and data memories are also used by the switch's serial ports in fixed memory cycles. A repeating phase schedule marks those cycles as busy. A processor access waits for the first free cycle of its target memory, which means the acknowledge delay depends on when the access arrives. The data memory has more busy cycles than the connection memory, so its worst-case delay is longer. The processor can only read the data memory. The serial receive side fills it through a separate write port.

Top module: `mpu_port`

## Requirements
- R1: After reset, ack_no is 1, data_oe_o is 0, the control register reads 0x00, and every memory location reads 0x00.
- R2: Address bit 5 low selects the control register, whatever the other address bits are. Address bit 5 high selects channel location addr_i[4:0], from 0 to 31.
- R3: Control register bits [4:3] choose the store for channel locations: 2'b10 selects connection memory high, 2'b11 selects connection memory low, and 2'b00 or 2'b01 select the data memory. The other bits are stored and read back, and they have no effect on the access.
- R4: data_oe_o is 1 only while a read is acknowledged and cs_ni and ds_ni are both low. data_o then carries the read value.
- R5: Once ack_no is low, it stays low for as long as cs_ni and ds_ni stay low. It returns high within a few cycles after either one is raised.
- R6: Serial-port cycles have priority. The phase counter runs modulo 8. Connection memory is busy in phases 0 to 3 and data memory is busy in phases 0 to 5. A bus access to a memory completes only in a free phase of that memory.
- R7: A control-register access is acknowledged on the 4th rising edge after the strobe is asserted. A connection-memory access is acknowledged within 800 ns, which is 8 cycles at a 100 ns clock.
- R8: A data-memory access is acknowledged within 1220 ns, which is 12 cycles at a 100 ns clock.
- R9: A bus write to the data memory is acknowledged and leaves the data memory unchanged.
- R10: A serial-port write through tdm_we_i, tdm_addr_i and tdm_data_i stores a byte in the data memory, and a bus read returns that byte.
- R11: Connection memory high and connection memory low are separate stores. A write to one does not alter the same channel in the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| ds_ni | input | 1 | Data strobe, active low |
| rw_i | input | 1 | 1 = read, 0 = write |
| addr_i | input | 6 | Bit 5 selects register or channel, bits 4:0 give the channel |
| data_i | input | 8 | Write data from the processor |
| data_o | output | 8 | Read data to the processor |
| data_oe_o | output | 1 | Enable for the data_o bus driver |
| ack_no | output | 1 | Data acknowledge, active low |
| tdm_we_i | input | 1 | Serial receive write strobe into the data memory |
| tdm_addr_i | input | 5 | Channel of the serial write |
| tdm_data_i | input | 8 | Byte of the serial write |

## Verification
Each memory type is accessed with 0 to 7 idle cycles placed before the strobe. This moves the request through every phase of the busy schedule, so a bound violation shows up at whichever phase causes the longest wait. The two connection stores are each written with different values at the same channel and then read back. This separates a correct store select from a mux that reads the wrong store. The control register is loaded with values whose non-select bits are set, to show that those bits are kept but have no effect on routing. Data memory contents are written through the serial port, then overwritten from the bus and read again, to show that the bus cannot write that store.

// File: rtl/mpu_port_pkg.sv
package mpu_port_pkg;
  localparam int SEL_LSB = 3;

  typedef enum logic [1:0] {TGT_CTRL, TGT_DM, TGT_CMH, TGT_CML} tgt_e;
  typedef enum logic [1:0] {ST_IDLE, ST_SERVE, ST_ACK} st_e;

  function automatic tgt_e decode_tgt(logic chan_sel, logic [1:0] mem_sel);
    if (!chan_sel) return TGT_CTRL;
    case (mem_sel)
      2'b10:   return TGT_CMH;
      2'b11:   return TGT_CML;
      default: return TGT_DM;
    endcase
  endfunction
endpackage

// File: rtl/mpu_port_sync.sv
module mpu_port_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[s] <= '0;
        else         chain_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[s] <= '0;
        else         chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/mpu_port_sched.sv
// Memory-timing model: fixed phases reserved for the serial ports.
module mpu_port_sched #(
  parameter int PHASES  = 8,
  parameter int CM_BUSY = 4,
  parameter int DM_BUSY = 6,
  localparam int PW     = $clog2(PHASES)
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic cm_busy_o,
  output logic dm_busy_o
);
  logic [PW-1:0] phase_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                          phase_q <= '0;
    else if (phase_q == PW'(PHASES - 1))  phase_q <= '0;
    else                                  phase_q <= phase_q + 1'b1;

  assign cm_busy_o = phase_q < PW'(CM_BUSY);
  assign dm_busy_o = phase_q < PW'(DM_BUSY);
endmodule

// File: rtl/mpu_port_mem.sv
module mpu_port_mem #(
  parameter int W     = 8,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/mpu_port.sv
module mpu_port
  import mpu_port_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int CHANS     = 32,
  parameter int PHASES    = 8,
  parameter int CM_BUSY   = 4,
  parameter int DM_BUSY   = 6,
  parameter int CLK_NS    = 100,
  parameter int CM_ACK_NS = 800,
  parameter int DM_ACK_NS = 1220,
  localparam int CH_W     = $clog2(CHANS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              ds_ni,
  input  logic              rw_i,
  input  logic [CH_W:0]     addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              ack_no,
  input  logic              tdm_we_i,
  input  logic [CH_W-1:0]   tdm_addr_i,
  input  logic [DATA_W-1:0] tdm_data_i
);
  localparam int N_CM = 2;

  logic [1:0]        strb_sync;
  logic              strb_s;
  logic              cm_busy, dm_busy;
  st_e               state_q;
  logic [CH_W:0]     addr_q;
  logic              rw_q;
  logic [DATA_W-1:0] wdata_q, rdata_q, ctrl_q, rd_mux, dm_rd;
  logic [DATA_W-1:0] cm_rd [N_CM];
  logic [N_CM-1:0]   cm_we;
  tgt_e              tgt;
  logic              tgt_busy, serve_go, serve_st, tgt_dm;

  mpu_port_sync #(.W(2), .STAGES(2)) u_sync (
    .clk_i, .rst_ni,
    .d_i ({~cs_ni, ~ds_ni}),
    .q_o (strb_sync)
  );
  assign strb_s = &strb_sync;

  mpu_port_sched #(.PHASES(PHASES), .CM_BUSY(CM_BUSY), .DM_BUSY(DM_BUSY)) u_sched (
    .clk_i, .rst_ni,
    .cm_busy_o (cm_busy),
    .dm_busy_o (dm_busy)
  );

  assign tgt = decode_tgt(addr_q[CH_W], ctrl_q[SEL_LSB+1:SEL_LSB]);

  always_comb begin
    case (tgt)
      TGT_DM:           tgt_busy = dm_busy;
      TGT_CMH, TGT_CML: tgt_busy = cm_busy;
      default:          tgt_busy = 1'b0;
    endcase
  end

  assign serve_st = state_q == ST_SERVE;
  assign serve_go = serve_st && !tgt_busy;
  assign tgt_dm   = tgt == TGT_DM;

  // connection stores: index 0 = high, 1 = low
  for (genvar m = 0; m < N_CM; m++) begin : g_cm
    assign cm_we[m] = serve_go && !rw_q && (tgt == ((m == 0) ? TGT_CMH : TGT_CML));
    mpu_port_mem #(.W(DATA_W), .DEPTH(CHANS)) u_cm (
      .clk_i, .rst_ni,
      .we_i    (cm_we[m]),
      .waddr_i (addr_q[CH_W-1:0]),
      .wdata_i (wdata_q),
      .raddr_i (addr_q[CH_W-1:0]),
      .rdata_o (cm_rd[m])
    );
  end

  // data memory: written only by the serial receive side
  mpu_port_mem #(.W(DATA_W), .DEPTH(CHANS)) u_dm (
    .clk_i, .rst_ni,
    .we_i    (tdm_we_i),
    .waddr_i (tdm_addr_i),
    .wdata_i (tdm_data_i),
    .raddr_i (addr_q[CH_W-1:0]),
    .rdata_o (dm_rd)
  );

  always_comb begin
    case (tgt)
      TGT_CMH: rd_mux = cm_rd[0];
      TGT_CML: rd_mux = cm_rd[1];
      TGT_DM:  rd_mux = dm_rd;
      default: rd_mux = ctrl_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      rw_q    <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
      ctrl_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (strb_s) begin
          addr_q  <= addr_i;
          rw_q    <= rw_i;
          wdata_q <= data_i;
          state_q <= ST_SERVE;
        end
        ST_SERVE: if (!tgt_busy) begin
          if (!rw_q && tgt == TGT_CTRL) ctrl_q <= wdata_q;
          rdata_q <= rd_mux;
          state_q <= ST_ACK;
        end
        default: if (!strb_s) state_q <= ST_IDLE;
      endcase
    end

  assign ack_no    = state_q != ST_ACK;
  assign data_oe_o = !ack_no && rw_q && rw_i && !cs_ni && !ds_ni;
  assign data_o    = rdata_q;
endmodule

// File: rtl/mpu_port_chk.sv
module mpu_port_chk #(
  parameter int CLK_NS    = 100,
  parameter int CM_ACK_NS = 800,
  parameter int DM_ACK_NS = 1220,
  localparam int CM_MAX   = CM_ACK_NS / CLK_NS,
  localparam int DM_MAX   = DM_ACK_NS / CLK_NS
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_ni,
  input logic ds_ni,
  input logic rw_i,
  input logic data_oe_o,
  input logic ack_no,
  input logic serving_i,
  input logic tgt_busy_i,
  input logic tgt_dm_i
);
  logic [7:0] wait_q;
  logic       pend;

  assign pend = !cs_ni && !ds_ni && ack_no;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)               wait_q <= '0;
    else if (!pend)            wait_q <= '0;
    else if (wait_q != 8'hff)  wait_q <= wait_q + 1'b1;

  a_r4_drive_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (rw_i && !cs_ni && !ds_ni && !ack_no));

  a_r5_ack_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ack_no && !cs_ni && !ds_ni) |=> !ack_no);

  a_r6_tdm_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (serving_i && tgt_busy_i) |=> ack_no);

  a_r7_cm_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend && !tgt_dm_i) |-> (wait_q < 8'(CM_MAX)));

  a_r8_dm_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend && tgt_dm_i) |-> (wait_q < 8'(DM_MAX)));
endmodule

bind mpu_port mpu_port_chk #(
  .CLK_NS(CLK_NS), .CM_ACK_NS(CM_ACK_NS), .DM_ACK_NS(DM_ACK_NS)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_ni      (cs_ni),
  .ds_ni      (ds_ni),
  .rw_i       (rw_i),
  .data_oe_o  (data_oe_o),
  .ack_no     (ack_no),
  .serving_i  (serve_st),
  .tgt_busy_i (tgt_busy),
  .tgt_dm_i   (tgt_dm)
);

// File: tb/mpu_port_bench.sv
module mpu_port_bench;
  localparam int PER    = 100;
  localparam int CM_LIM = 800 / PER;
  localparam int DM_LIM = 1220 / PER;
  localparam int CR_LAT = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs_ni = 1'b1, ds_ni = 1'b1, rw_i = 1'b1;
  logic [5:0] addr_i = '0;
  logic [7:0] data_i = '0;
  logic [7:0] data_o;
  logic       data_oe_o, ack_no;
  logic       tdm_we_i = 1'b0;
  logic [4:0] tdm_addr_i = '0;
  logic [7:0] tdm_data_i = '0;

  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  string      req_q[$];

  always #(PER/2) clk_i = ~clk_i;

  mpu_port u_mpu_port (
    .clk_i, .rst_ni, .cs_ni, .ds_ni, .rw_i, .addr_i, .data_i,
    .data_o, .data_oe_o, .ack_no, .tdm_we_i, .tdm_addr_i, .tdm_data_i
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: sampled a quarter period after the rising edge
  logic oe_prev = 1'b0;
  always begin
    @(posedge clk_i);
    #(PER/4);
    if (data_oe_o && !oe_prev) begin
      if (exp_q.size() == 0) check(1'b0, "R4 unexpected drive", data_o, 0);
      else begin
        logic [7:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        check(data_o == e, r, data_o, e);
      end
    end
    if (data_oe_o && (!rw_i || cs_ni || ds_ni))
      check(1'b0, "R4 drive outside read", data_oe_o, 0);
    oe_prev = data_oe_o;
  end

  task automatic access(input bit rd, input logic [5:0] a, input logic [7:0] wd,
                        input logic [7:0] exp, input int lim, input bit exact,
                        input string req);
    int lat, n;
    if (rd) begin exp_q.push_back(exp); req_q.push_back(req); end
    @(negedge clk_i);
    cs_ni = 1'b0; ds_ni = 1'b0; rw_i = rd; addr_i = a; data_i = wd;
    lat = 0;
    while (ack_no && lat < 40) begin @(negedge clk_i); lat++; end
    if (exact) check(lat == lim, {req, " latency"}, lat, lim);
    else       check(lat <= lim, {req, " latency bound"}, lat, lim);
    repeat (2) @(negedge clk_i);
    check(ack_no == 1'b0, "R5 ack held while strobed", ack_no, 0);
    cs_ni = 1'b1; ds_ni = 1'b1; rw_i = 1'b1;
    n = 0;
    while (!ack_no && n < 10) begin @(negedge clk_i); n++; end
    check(ack_no == 1'b1 && n <= 4, "R5 ack released", n, 4);
    check(data_oe_o == 1'b0, "R4 bus released", data_oe_o, 0);
    @(negedge clk_i);
  endtask

  task automatic tdm_write(input logic [4:0] ch, input logic [7:0] d);
    @(negedge clk_i);
    tdm_we_i = 1'b1; tdm_addr_i = ch; tdm_data_i = d;
    @(negedge clk_i);
    tdm_we_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    check(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(ack_no == 1'b1, "R1 ack idle", ack_no, 1);
    check(data_oe_o == 1'b0, "R1 bus idle", data_oe_o, 0);
    access(1, 6'h00, 0, 8'h00, CR_LAT, 1, "R1 ctrl reset value");
    access(1, 6'h20, 0, 8'h00, DM_LIM, 0, "R1 dm reset value");

    // R2: control write via a different low address, read back elsewhere
    access(0, 6'h1f, 8'h10, 0, CR_LAT, 1, "R7 ctrl write");
    access(1, 6'h05, 0, 8'h10, CR_LAT, 1, "R2 ctrl alias read");

    // R11: distinct values in high and low stores at the same channel
    access(0, 6'h20, 8'ha5, 0, CM_LIM, 0, "R7 cmh write ch0");
    access(0, 6'h3f, 8'h3c, 0, CM_LIM, 0, "R7 cmh write ch31");
    access(0, 6'h00, 8'h18, 0, CR_LAT, 1, "R3 select low");
    access(0, 6'h20, 8'h5a, 0, CM_LIM, 0, "R7 cml write ch0");
    access(1, 6'h20, 0, 8'h5a, CM_LIM, 0, "R11 cml read ch0");
    access(1, 6'h3f, 0, 8'h00, CM_LIM, 0, "R11 cml ch31 untouched");
    access(0, 6'h00, 8'h10, 0, CR_LAT, 1, "R3 select high");
    access(1, 6'h20, 0, 8'ha5, CM_LIM, 0, "R11 cmh ch0 kept");
    access(1, 6'h3f, 0, 8'h3c, CM_LIM, 0, "R2 cmh ch31");

    // R3: non-select bits stored and inert
    access(0, 6'h00, 8'hf7, 0, CR_LAT, 1, "R3 ctrl extra bits");
    access(1, 6'h00, 0, 8'hf7, CR_LAT, 1, "R3 ctrl readback");
    access(1, 6'h20, 0, 8'ha5, CM_LIM, 0, "R3 extra bits no effect");

    // R10, R9: data memory
    tdm_write(5'd5, 8'h77);
    access(0, 6'h00, 8'h08, 0, CR_LAT, 1, "R3 select dm");
    access(1, 6'h25, 0, 8'h77, DM_LIM, 0, "R10 dm read");
    access(0, 6'h25, 8'h11, 0, DM_LIM, 0, "R9 dm bus write acked");
    access(1, 6'h25, 0, 8'h77, DM_LIM, 0, "R9 dm unchanged");

    // R6, R7, R8: sweep arrival phase
    for (int off = 0; off < 8; off++) begin
      repeat (off) @(negedge clk_i);
      access(1, 6'h25, 0, 8'h77, DM_LIM, 0, "R8 dm phase sweep");
    end
    access(0, 6'h00, 8'h10, 0, CR_LAT, 1, "R3 select high again");
    for (int off = 0; off < 8; off++) begin
      repeat (off) @(negedge clk_i);
      access(1, 6'h3f, 0, 8'h3c, CM_LIM, 0, "R6 cm phase sweep");
    end

    repeat (4) @(negedge clk_i);
    check(exp_q.size() == 0, "R4 reads all driven", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule